// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the digital core of a small serial memory device. The array holds 64 words of 16 bits in registers. A host selects the device with a chip-select line and clocks framed instructions in on a data line with a shift clock. The block decodes the instructions and then does one of four things: it streams a word back, reprograms one word or the whole array, erases one word or the whole array to all-ones, or opens and closes a program-enable latch. All three serial inputs are synchronised into the system clock domain, and shift-clock rising edges are found there.

Every programming command runs a self-timed interval, counted in system clocks. The device takes no new instructions while that interval runs. If the host deselects the device and then selects it again during the interval, the data line reports busy (0) and later ready (1). The data line is driven only while read data or status is being presented. Otherwise the output enable is low, and the pad above the block is left floating.

Top module: `sermem_slave`

## Requirements
- R1: After reset every word reads as 16'hFFFF, the program-enable latch is clear and `do_oe_o` is low.
- R2: An instruction is a start bit, then a 2-bit opcode, then a 6-bit address sent MSB first. The start bit is the first 1 sampled on a shift-clock rising edge after select, so 0s sent before it are skipped. Opcode 2'b10 is read. After the last address bit, the output presents a dummy 0. Each later shift-clock rising edge then moves out the next data bit, MSB first, for 16 bits.
- R3: Opcode 2'b00 is an extended command chosen by the top two address bits: 2'b11 sets the latch and 2'b00 clears it. While the latch is clear, write, erase, erase-all and write-all change nothing and start no programming interval.
- R4: Opcode 2'b01 (write) takes 16 data bits, MSB first, after the address. It replaces the word directly, with no prior erase needed.
- R5: Opcode 2'b11 (erase) sets the addressed word to 16'hFFFF.
- R6: Extended code 2'b10 (erase-all) sets every word to 16'hFFFF.
- R7: Extended code 2'b01 (write-all) takes 16 data bits and writes them to every word.
- R8: An accepted programming command starts a busy interval of `PROG_CYCLES` system clocks. An instruction whose select begins during that interval is ignored.
- R9: If select rises while busy, `do_oe_o` goes high and `do_o` shows 0 until the interval ends, then 1 until select falls. If select rises while not busy, no status is driven.
- R10: `do_oe_o` is low whenever select is low, and it is high only during read output or status.
- R11: Lowering select before the last bit of an instruction aborts it: the array does not change and no busy interval starts.
- R12: Reads return the stored word whether the latch is set or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sk_i | input | 1 | Serial shift clock, asynchronous |
| di_i | input | 1 | Serial data in, sampled on shift-clock rising edges |
| do_o | output | 1 | Serial data out: read data or ready/busy status |
| do_oe_o | output | 1 | Output enable for `do_o`; low means high impedance |

## Verification
The assertions check four properties on every cycle:
- the output enable drops one cycle after the synchronised select falls;
- no array write or fill happens while the latch is clear or a programming interval runs;
- the interval timer is never restarted while busy, and does not stop early;
- the status bit tracks the busy state.

Only the bench's scenarios can show the rest. That covers the serial framing and bit order of read data and the final array contents after each command. It also covers instructions being dropped during busy or when aborted, and the length of the busy interval as seen from the pins.

// File: rtl/sermem_pkg.sv
// Shared types for the three-wire serial memory slave.
// Assumes the opcode field is two bits wide and extended commands use the top two address bits.
package sermem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // deselected
        ST_START,   // selected, waiting for the start bit
        ST_HEAD,    // shifting opcode and address
        ST_DATA,    // shifting write data
        ST_READ,    // presenting read data
        ST_STATUS,  // presenting ready/busy
        ST_HOLD     // instruction finished, waiting for deselect
    } sm_state_e;

    typedef enum logic [1:0] {
        OPC_EXT   = 2'b00,
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10,
        OPC_ERASE = 2'b11
    } opcode_e;

    localparam logic [1:0] XC_LOCK  = 2'b00;
    localparam logic [1:0] XC_FILL  = 2'b01;
    localparam logic [1:0] XC_CLEAR = 2'b10;
    localparam logic [1:0] XC_OPEN  = 2'b11;

endpackage

// File: rtl/sermem_sync.sv
// Input synchroniser and shift-clock edge finder.
// Assumes cs, sk and di are asynchronous; all three pass through the same chain so their order is kept.
module sermem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic cs_o,
    output logic di_o,
    output logic sk_rise_o
);
    logic [2:0] pipe [STAGES];
    logic       sk_last;

    // Shift the three raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= {cs_i, sk_i, di_i};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    // Remember the last synchronised shift-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sk_last <= 1'b0;
        else        sk_last <= pipe[STAGES-1][1];
    end

    assign cs_o      = pipe[STAGES-1][2];
    assign di_o      = pipe[STAGES-1][0];
    assign sk_rise_o = pipe[STAGES-1][1] & ~sk_last;
endmodule

// File: rtl/sermem_array.sv
// Register-based word array with one write port, a whole-array fill and one combinational read port.
// Assumes write and fill never arrive in the same cycle; contents reset to all-ones.
module sermem_array #(
    parameter int WORDS = 64,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             fill,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [WORDS];

    // Update one word on a write, or every word on a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else begin
            for (int i = 0; i < WORDS; i++) begin
                if (fill || (we && waddr == AW'(i))) mem[i] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];

    p_one_port_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({we, fill}));
endmodule

// File: rtl/sermem_timer.sv
// Self-timed programming interval: busy for CYCLES clocks after a start pulse.
// Assumes start is only pulsed while idle.
module sermem_timer #(
    parameter int  CYCLES = 2000,
    localparam int CW     = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CW-1:0] cnt;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy);
    p_no_early_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != CW'(1)) |=> busy);
endmodule

// File: rtl/sermem_slave.sv
// Three-wire serial memory slave: instruction framing, program-enable latch, read streaming,
// programming commands and ready/busy status.
// Assumes sk is slow against clk (each level held for several clk cycles).
module sermem_slave
    import sermem_pkg::*;
#(
    parameter int  WORDS       = 64,
    parameter int  WIDTH       = 16,
    parameter int  PROG_CYCLES = 2000,
    parameter int  SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe_o
);
    localparam int AW   = $clog2(WORDS);
    localparam int HB   = 2 + AW;
    localparam int MAXB = (WIDTH > HB) ? WIDTH : HB;
    localparam int CNTW = $clog2(MAXB) + 1;

    logic             cs_s, di_s, sk_rise;
    sm_state_e        st;
    logic [CNTW-1:0]  bitcnt;
    logic [HB-1:0]    hd_q;
    logic [WIDTH-1:0] dsr_q, osr_q, wdata_q, rdata;
    logic [AW-1:0]    waddr_q;
    logic             en_q, arr_we_q, fill_q, start_q, busy, oe_q, do_q;

    logic [HB-1:0]    hd_next;
    logic [WIDTH-1:0] dw_next;
    opcode_e          op_now, op_held;
    logic [1:0]       xcode;

    sermem_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i),
        .cs_o(cs_s), .di_o(di_s), .sk_rise_o(sk_rise)
    );

    sermem_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u_array (
        .clk(clk), .rst_n(rst_n), .we(arr_we_q), .fill(fill_q),
        .waddr(waddr_q), .wdata(wdata_q), .raddr(hd_next[AW-1:0]), .rdata(rdata)
    );

    sermem_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start_q), .busy(busy)
    );

    // Decode views of the header and data shifters including the bit arriving now.
    always_comb begin
        hd_next = {hd_q[HB-2:0], di_s};
        dw_next = {dsr_q[WIDTH-2:0], di_s};
        op_now  = opcode_e'(hd_next[HB-1:HB-2]);
        op_held = opcode_e'(hd_q[HB-1:HB-2]);
        xcode   = hd_next[AW-1:AW-2];
    end

    // Instruction sequencer: framing, decode, commit pulses and output drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            bitcnt   <= '0;
            hd_q     <= '0;
            dsr_q    <= '0;
            osr_q    <= '0;
            wdata_q  <= '0;
            waddr_q  <= '0;
            en_q     <= 1'b0;
            arr_we_q <= 1'b0;
            fill_q   <= 1'b0;
            start_q  <= 1'b0;
            oe_q     <= 1'b0;
            do_q     <= 1'b0;
        end else begin
            arr_we_q <= 1'b0;
            fill_q   <= 1'b0;
            start_q  <= 1'b0;
            if (!cs_s) begin
                st   <= ST_IDLE;
                oe_q <= 1'b0;
                do_q <= 1'b0;
            end else begin
                case (st)
                    ST_IDLE: begin
                        if (busy) begin
                            st   <= ST_STATUS;
                            oe_q <= 1'b1;
                            do_q <= 1'b0;
                        end else begin
                            st <= ST_START;
                        end
                    end
                    ST_START: begin
                        if (sk_rise && di_s) begin
                            st     <= ST_HEAD;
                            bitcnt <= '0;
                        end
                    end
                    ST_HEAD: begin
                        if (sk_rise) begin
                            hd_q   <= hd_next;
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == CNTW'(HB - 1)) begin
                                waddr_q <= hd_next[AW-1:0];
                                bitcnt  <= '0;
                                st      <= ST_HOLD;
                                case (op_now)
                                    OPC_READ: begin
                                        osr_q <= rdata;
                                        oe_q  <= 1'b1;
                                        do_q  <= 1'b0;
                                        st    <= ST_READ;
                                    end
                                    OPC_WRITE: st <= ST_DATA;
                                    OPC_ERASE: begin
                                        wdata_q  <= '1;
                                        arr_we_q <= en_q;
                                        start_q  <= en_q;
                                    end
                                    default: begin
                                        case (xcode)
                                            XC_OPEN:  en_q <= 1'b1;
                                            XC_LOCK:  en_q <= 1'b0;
                                            XC_CLEAR: begin
                                                wdata_q <= '1;
                                                fill_q  <= en_q;
                                                start_q <= en_q;
                                            end
                                            default:  st <= ST_DATA;
                                        endcase
                                    end
                                endcase
                            end
                        end
                    end
                    ST_DATA: begin
                        if (sk_rise) begin
                            dsr_q  <= dw_next;
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == CNTW'(WIDTH - 1)) begin
                                wdata_q <= dw_next;
                                start_q <= en_q;
                                if (op_held == OPC_WRITE) arr_we_q <= en_q;
                                else                      fill_q   <= en_q;
                                st <= ST_HOLD;
                            end
                        end
                    end
                    ST_READ: begin
                        oe_q <= 1'b1;
                        if (sk_rise) begin
                            do_q  <= osr_q[WIDTH-1];
                            osr_q <= {osr_q[WIDTH-2:0], 1'b0};
                        end
                    end
                    ST_STATUS: begin
                        oe_q <= 1'b1;
                        do_q <= ~busy;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign do_o    = do_q;
    assign do_oe_o = oe_q;

    p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n) !cs_s |=> !do_oe_o);
    p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n) (arr_we_q || fill_q) |-> en_q);
    p_idle_prog_r8: assert property (@(posedge clk) disable iff (!rst_n) (arr_we_q || fill_q) |-> !busy);
    p_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STATUS && $past(st == ST_STATUS)) |-> (do_oe_o && do_o == !$past(busy)));
endmodule

// File: tb/sermem_slave_test.sv
module sermem_slave_test;
    localparam int PROG = 600;
    localparam int HALF = 6;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_w, oe_w;
    int   total = 0, fails = 0;
    logic [15:0] model [64];
    logic en_m = 1'b0;

    always #5 clk = ~clk;

    sermem_slave #(.PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
        .do_o(do_w), .do_oe_o(oe_w)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        di = b; wclk(HALF); sk = 1'b1; wclk(HALF); sk = 1'b0;
    endtask

    task automatic sel_on();
        @(negedge clk); cs = 1'b1; wclk(HALF);
    endtask

    task automatic sel_off();
        @(negedge clk); cs = 1'b0; di = 1'b0; wclk(8);
    endtask

    task automatic send_head(input logic [1:0] op, input logic [5:0] a);
        send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 5; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic send_word(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) send_bit(d[i]);
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] v, input int zeros);
        logic dummy;
        sel_on();
        for (int i = 0; i < zeros; i++) send_bit(1'b0);
        send_head(2'b10, a);
        v = '0;
        for (int i = 0; i < 17; i++) begin
            wclk(HALF);
            if (i == 0) begin
                dummy = do_w;
                chk("R2 dummy bit", {31'd0, dummy}, 32'd0);
                chk("R10 oe during read", {31'd0, oe_w}, 32'd1);
            end else begin
                v = {v[14:0], do_w};
            end
            sk = 1'b1; wclk(HALF); sk = 1'b0;
        end
        sel_off();
        chk("R10 oe after deselect", {31'd0, oe_w}, 32'd0);
    endtask

    task automatic rd_check(input string tag, input logic [5:0] a);
        logic [15:0] v;
        rd(a, v, 0);
        chk(tag, {16'd0, v}, {16'd0, model[a]});
    endtask

    task automatic wait_ready(output int n);
        sel_on();
        wclk(2);
        n = HALF + 2;
        chk("R9 status busy oe", {31'd0, oe_w}, 32'd1);
        chk("R9 status busy value", {31'd0, do_w}, 32'd0);
        while (do_w !== 1'b1 && n < PROG + 200) begin
            wclk(1); n++;
        end
        chk("R9 status ready", {31'd0, do_w}, 32'd1);
        sel_off();
    endtask

    task automatic expect_idle(input string tag);
        sel_on(); wclk(4);
        chk(tag, {31'd0, oe_w}, 32'd0);
        sel_off();
    endtask

    task automatic cmd(input logic [1:0] op, input logic [5:0] a, input logic has_d, input logic [15:0] d);
        sel_on();
        send_head(op, a);
        if (has_d) send_word(d);
        sel_off();
    endtask

    initial begin : main
        int n;
        logic [15:0] v, d;
        logic [5:0] a;
        int unsigned seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        wclk(4); rst_n = 1'b1; wclk(4);

        chk("R1 oe after reset", {31'd0, oe_w}, 32'd0);
        rd_check("R1 word 0 after reset", 6'd0);
        rd_check("R1 word 63 after reset", 6'd63);

        // Locked write must do nothing
        cmd(2'b01, 6'd5, 1'b1, 16'h1234);
        expect_idle("R3 no busy when locked");
        rd_check("R3 locked write ignored", 6'd5);

        // Enable, write, status timing
        cmd(2'b00, 6'b110000, 1'b0, 16'h0); en_m = 1'b1;
        expect_idle("R3 enable starts no interval");
        cmd(2'b01, 6'd5, 1'b1, 16'hA5C3); model[5] = 16'hA5C3;
        // Instruction during busy is dropped
        cmd(2'b01, 6'd6, 1'b1, 16'h0000);
        wait_ready(n);
        expect_idle("R9 no status after interval");
        rd_check("R4 write stored", 6'd5);
        rd_check("R8 write during busy ignored", 6'd6);

        cmd(2'b01, 6'd9, 1'b1, 16'h5A5A); model[9] = 16'h5A5A;
        wait_ready(n);
        chk("R8 interval not short", {31'd0, n > PROG - 60}, 32'd1);
        chk("R8 interval not long", {31'd0, n <= PROG}, 32'd1);

        cmd(2'b01, 6'd5, 1'b1, 16'h0F3C); model[5] = 16'h0F3C;
        wait_ready(n);
        rd_check("R4 overwrite without erase", 6'd5);

        cmd(2'b11, 6'd5, 1'b0, 16'h0); model[5] = 16'hFFFF;
        wait_ready(n);
        rd_check("R5 erase word", 6'd5);

        // Abort mid data
        sel_on(); send_head(2'b01, 6'd7);
        for (int i = 0; i < 10; i++) send_bit(1'b0);
        sel_off();
        expect_idle("R11 abort starts no interval");
        rd_check("R11 abort leaves word", 6'd7);

        // Leading zeros before start bit
        rd(6'd9, v, 3);
        chk("R2 leading zeros skipped", {16'd0, v}, {16'd0, model[9]});

        // Random mix
        for (int i = 0; i < 24; i++) begin
            int k;
            k = $urandom % 8;
            a = 6'($urandom);
            d = 16'($urandom);
            case (k)
                0, 1, 2: begin
                    cmd(2'b01, a, 1'b1, d);
                    if (en_m) begin model[a] = d; wait_ready(n); end
                    else expect_idle("R3 locked random write");
                    rd_check(en_m ? "R4 random write" : "R12 read while locked", a);
                end
                3: begin
                    cmd(2'b11, a, 1'b0, 16'h0);
                    if (en_m) begin model[a] = 16'hFFFF; wait_ready(n); end
                    else expect_idle("R3 locked random erase");
                    rd_check("R5 random erase", a);
                end
                6: begin
                    en_m = ~en_m;
                    cmd(2'b00, en_m ? 6'b110101 : 6'b001010, 1'b0, 16'h0);
                end
                default: rd_check("R12 random read", a);
            endcase
        end

        // Locked whole-array commands ignored
        cmd(2'b00, 6'b000000, 1'b0, 16'h0); en_m = 1'b0;
        cmd(2'b00, 6'b011111, 1'b1, 16'h1357);
        expect_idle("R3 locked write-all no interval");
        cmd(2'b00, 6'b100000, 1'b0, 16'h0);
        expect_idle("R3 locked erase-all no interval");
        rd_check("R3 locked fill ignored", 6'd9);

        cmd(2'b00, 6'b111111, 1'b0, 16'h0); en_m = 1'b1;
        cmd(2'b00, 6'b010000, 1'b1, 16'hC0DE);
        wait_ready(n);
        for (int i = 0; i < 64; i++) model[i] = 16'hC0DE;
        rd_check("R7 write-all low", 6'd0);
        rd_check("R7 write-all high", 6'd63);
        rd_check("R7 write-all mid", 6'd21);

        cmd(2'b00, 6'b101010, 1'b0, 16'h0);
        wait_ready(n);
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        rd_check("R6 erase-all low", 6'd0);
        rd_check("R6 erase-all mid", 6'd40);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule